// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

A multi-cycle unit that adds or subtracts two 32-bit IEEE-754 single-precision numbers. Each operand is laid out as a sign at bit 31, an 8-bit excess-127 exponent at bits 30:23 and a 23-bit fraction at bits 22:0. An operand pair and an add/subtract select enter through a valid/ready handshake. The result leaves through a second valid/ready handshake with an overflow flag and an underflow flag.

Internally a small controller walks the datapath through a fixed order of steps. It captures the operands and puts the hidden one back on each nonzero operand. It aligns the smaller operand to the larger exponent, collecting guard, round and sticky bits on the way. It then combines the two significands by magnitude, normalizes one place per cycle, rounds to nearest-even, renormalizes and packs. Because of the normalize loop, an operation takes a variable number of cycles, and the caller simply waits for the output valid.

Subnormal inputs are read as zero. Results that fall below the normal range are flushed to signed zero. Results above it saturate to signed infinity. There is no NaN handling and no rounding mode other than nearest-even.

Top module: `fpadd_top`

## Requirements
- R1: Operands with equal signs give the correctly rounded sum, for example 1.0 + 1.0 = 0x40000000 and -1.5 + -1.5 = 0xC0400000.
- R2: With in_sub = 1 the result is A minus B, for example 1.0 - 3.0 = 0xC0000000.
- R3: When the effective signs differ, the smaller magnitude is subtracted from the larger. The result takes the sign of the larger magnitude, including when the exponents are equal (1.5 - 1.75 = 0xBE800000).
- R4: An exactly zero sum, such as x - x, returns +0 (0x00000000) with both flags low.
- R5: The operand with the smaller exponent is shifted right by the exponent difference. An operand more than 25 places below the other does not change the result (1.0 + 2^-30 = 0x3F800000).
- R6: Rounding is to nearest. A tie rounds to the value whose fraction bit 0 is 0: 1.0 + 2^-24 = 0x3F800000 and 0x3F800001 + 2^-24 = 0x3F800002. Above a tie the result rounds up: 1.0 + 1.5*2^-24 = 0x3F800001.
- R7: The sum is normalized to 1.xxx before rounding. A rounding carry out of the top bit renormalizes the result and increments the exponent (0x3FFFFFFF + 2^-24 = 0x40000000).
- R8: A biased result exponent above 254 raises out_overflow and returns signed infinity (exponent field 0xFF, fraction 0).
- R9: A biased result exponent below 1 raises out_underflow and returns zero carrying the result's sign (bit 31 only).
- R10: An operand whose exponent field is 0 counts as zero whatever its fraction. x + 0 returns x unchanged, and -0 + -0 returns +0.
- R11: in_ready is high only while the unit is idle. Operands offered while it is busy are ignored. Once out_valid rises, it stays high with out_result and the flags unchanged until out_ready is seen high.
- R12: After reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit idle and able to accept an operand pair |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_sub | input | 1 | 1 selects A - B, 0 selects A + B |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Packed single-precision result |
| out_overflow | output | 1 | Result saturated to infinity |
| out_underflow | output | 1 | Result flushed to zero |

## Verification
The assertions take for granted that operands are normalized numbers or zeros, with no NaN or infinity codes. They also assume out_ready is sampled only while a result is pending. Under these conditions the controller's round strobe always meets a sum already in the 01.xxx form, and the flags match the saturated or flushed codes. The stimulus uses only finite normal, zero or subnormal encodings. It offers a pair only from the idle state, except for the deliberate busy-time offer that checks R11 at the result port.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  typedef struct packed {
    logic load;
    logic align;
    logic add;
    logic norm;
    logic round;
  } strobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ALIGN, S_ADD, S_NORM, S_ROUND, S_DONE
  } state_t;
endpackage

// File: rtl/fpadd_ctrl.sv
module fpadd_ctrl
  import fpadd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    inValid,
  output logic    inReady,
  output logic    outValid,
  input  logic    outReady,
  input  logic    normDone,
  output strobe_t stb
);
  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      S_IDLE: begin
        stb.load = inValid;
        if (inValid) nextState = S_ALIGN;
      end
      S_ALIGN: begin stb.align = 1'b1; nextState = S_ADD; end
      S_ADD:   begin stb.add   = 1'b1; nextState = S_NORM; end
      S_NORM: begin
        stb.norm = 1'b1;
        if (normDone) nextState = S_ROUND;
      end
      S_ROUND: begin stb.round = 1'b1; nextState = S_DONE; end
      S_DONE:  if (outReady) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign inReady  = (state == S_IDLE);
  assign outValid = (state == S_DONE);

  // R11: a pending result is held until it is taken
  assert_hold_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid);
  // R11: accepting and presenting never overlap
  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(inReady && outValid));
endmodule

// File: rtl/fpadd_dp.sv
module fpadd_dp
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD  = 1 + EXP_W + FRAC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  strobe_t         stb,
  input  logic [WORD-1:0] opA,
  input  logic [WORD-1:0] opB,
  input  logic            opSub,
  output logic            normDone,
  output logic [WORD-1:0] result,
  output logic            ovf,
  output logic            unf
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int EXT_W = SIG_W + 3;
  localparam int SUM_W = EXT_W + 1;
  localparam int EI_W  = EXP_W + 2;
  localparam int E_MAX = (1 << EXP_W) - 2;

  logic             sA, sB, sBig, sSmall, sRes;
  logic [EXP_W-1:0] eA, eB;
  logic [EXT_W-1:0] mA, mB, mBig, mSmall;
  logic signed [EI_W-1:0] eRes;
  logic [SUM_W-1:0] sum;
  logic [WORD-1:0]  resReg;
  logic             ovfReg, unfReg;

  // align step: order by {exponent, significand}, shift the smaller one
  logic             aBigger;
  logic [EXP_W-1:0] eHi, eLo, shiftAmt;
  logic [EXT_W-1:0] mHi, mLo, mShift;
  always_comb begin
    aBigger  = {eA, mA} >= {eB, mB};
    eHi      = aBigger ? eA : eB;
    eLo      = aBigger ? eB : eA;
    mHi      = aBigger ? mA : mB;
    mLo      = aBigger ? mB : mA;
    shiftAmt = eHi - eLo;
    if (shiftAmt >= EXP_W'(EXT_W)) begin
      mShift = {{(EXT_W-1){1'b0}}, |mLo};
    end else begin
      mShift    = mLo >> shiftAmt;
      mShift[0] = mShift[0] | (|(mLo & ~({EXT_W{1'b1}} << shiftAmt)));
    end
  end

  // round step: nearest-even, then renormalize on carry and pack
  logic             lsb, grd, rst, inc;
  logic [SIG_W:0]   rnd;
  logic signed [EI_W-1:0] eFin;
  logic [FRAC_W-1:0] fracFin;
  always_comb begin
    lsb = sum[3];
    grd = sum[2];
    rst = sum[1] | sum[0];
    inc = grd & (rst | lsb);
    rnd = {1'b0, sum[SUM_W-2:3]} + (SIG_W+1)'(inc);
    if (rnd[SIG_W]) begin
      fracFin = rnd[FRAC_W:1];
      eFin    = eRes + EI_W'(1);
    end else begin
      fracFin = rnd[FRAC_W-1:0];
      eFin    = eRes;
    end
  end

  assign normDone = (sum[SUM_W-1:SUM_W-2] == 2'b01) || (sum == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {sA, sB, sBig, sSmall, sRes} <= '0;
      {eA, eB, mA, mB, mBig, mSmall} <= '0;
      eRes   <= '0;
      sum    <= '0;
      resReg <= '0;
      ovfReg <= 1'b0;
      unfReg <= 1'b0;
    end else begin
      if (stb.load) begin
        sA <= opA[WORD-1];
        sB <= opB[WORD-1] ^ opSub;
        eA <= opA[WORD-2:FRAC_W];
        eB <= opB[WORD-2:FRAC_W];
        mA <= (opA[WORD-2:FRAC_W] != '0) ? {1'b1, opA[FRAC_W-1:0], 3'b000} : '0;
        mB <= (opB[WORD-2:FRAC_W] != '0) ? {1'b1, opB[FRAC_W-1:0], 3'b000} : '0;
      end
      if (stb.align) begin
        sBig   <= aBigger ? sA : sB;
        sSmall <= aBigger ? sB : sA;
        mBig   <= mHi;
        mSmall <= mShift;
        eRes   <= {2'b00, eHi};
      end
      if (stb.add) begin
        sRes <= sBig;
        sum  <= (sBig ^ sSmall) ? ({1'b0, mBig} - {1'b0, mSmall})
                                : ({1'b0, mBig} + {1'b0, mSmall});
      end
      if (stb.norm && !normDone) begin
        if (sum[SUM_W-1]) begin
          sum  <= {1'b0, sum[SUM_W-1:2], sum[1] | sum[0]};
          eRes <= eRes + EI_W'(1);
        end else begin
          sum  <= sum << 1;
          eRes <= eRes - EI_W'(1);
        end
      end
      if (stb.round) begin
        ovfReg <= 1'b0;
        unfReg <= 1'b0;
        if (sum == '0) begin
          resReg <= '0;
        end else if (int'(eFin) > E_MAX) begin
          resReg <= {sRes, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          ovfReg <= 1'b1;
        end else if (int'(eFin) < 1) begin
          resReg <= {sRes, {(WORD-1){1'b0}}};
          unfReg <= 1'b1;
        end else begin
          resReg <= {sRes, eFin[EXP_W-1:0], fracFin};
        end
      end
    end
  end

  assign result = resReg;
  assign ovf    = ovfReg;
  assign unf    = unfReg;

  // R7: the rounding step only ever sees a normalized (or zero) sum
  assert_norm_before_round_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.round && (sum != '0) |-> sum[SUM_W-1:SUM_W-2] == 2'b01);
  // R8: overflow flag comes with the infinity code
  assert_ovf_inf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> result[WORD-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});
  // R9: underflow flag comes with a zero magnitude
  assert_unf_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> result[WORD-2:0] == '0);
  // R8 R9: flags are exclusive
  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));
endmodule

// File: rtl/fpadd_top.sv
module fpadd_top
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD  = 1 + EXP_W + FRAC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [WORD-1:0] in_a,
  input  logic [WORD-1:0] in_b,
  input  logic            in_sub,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [WORD-1:0] out_result,
  output logic            out_overflow,
  output logic            out_underflow
);
  strobe_t stb;
  logic    normDone;

  fpadd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(in_valid), .inReady(in_ready),
    .outValid(out_valid), .outReady(out_ready), .normDone(normDone), .stb(stb)
  );

  fpadd_dp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .opA(in_a), .opB(in_b),
    .opSub(in_sub), .normDone(normDone), .result(out_result),
    .ovf(out_overflow), .unf(out_underflow)
  );

  // R11: the presented result does not change while it waits
  assert_stable_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_result) && $stable(out_overflow)
                                 && $stable(out_underflow));
endmodule

// File: tb/sim_fpadd_top.sv
module sim_fpadd_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0, inSub = 1'b0, outReady = 1'b0;
  logic [31:0] inA = '0, inB = '0;
  logic        inReady, outValid, ovf, unf;
  logic [31:0] res;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fpadd_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(inValid), .in_ready(inReady),
    .in_a(inA), .in_b(inB), .in_sub(inSub), .out_valid(outValid),
    .out_ready(outReady), .out_result(res), .out_overflow(ovf),
    .out_underflow(unf)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        sub;
    logic [31:0] r;
    logic        o;
    logic        u;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 1'b0, 1'b0, 8'd1},  // R1
    '{32'h3FC00000, 32'h40200000, 1'b0, 32'h40800000, 1'b0, 1'b0, 8'd1},  // R1
    '{32'hBFC00000, 32'hBFC00000, 1'b0, 32'hC0400000, 1'b0, 1'b0, 8'd1},  // R1
    '{32'h3F000000, 32'h3EE00000, 1'b1, 32'h3D800000, 1'b0, 1'b0, 8'd2},  // R2
    '{32'h3F800000, 32'h40400000, 1'b1, 32'hC0000000, 1'b0, 1'b0, 8'd2},  // R2
    '{32'h3F000000, 32'hBEE00000, 1'b0, 32'h3D800000, 1'b0, 1'b0, 8'd3},  // R3
    '{32'h3FC00000, 32'h3FE00000, 1'b1, 32'hBE800000, 1'b0, 1'b0, 8'd3},  // R3
    '{32'h3F800000, 32'h33800000, 1'b1, 32'h3F7FFFFF, 1'b0, 1'b0, 8'd3},  // R3
    '{32'h40400000, 32'h40400000, 1'b1, 32'h00000000, 1'b0, 1'b0, 8'd4},  // R4
    '{32'hC0200000, 32'h40200000, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'd4},  // R4
    '{32'h3F800000, 32'h30800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, 8'd5},  // R5
    '{32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, 8'd6},  // R6
    '{32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0, 8'd6},  // R6
    '{32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, 1'b0, 1'b0, 8'd6},  // R6
    '{32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0, 8'd7},  // R7
    '{32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0, 8'd8},  // R8
    '{32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000, 1'b1, 1'b0, 8'd8},  // R8
    '{32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 1'b0, 1'b1, 8'd9},  // R9
    '{32'h00800000, 32'h00800001, 1'b1, 32'h80000000, 1'b0, 1'b1, 8'd9},  // R9
    '{32'h00000000, 32'h40490FDB, 1'b0, 32'h40490FDB, 1'b0, 1'b0, 8'd10}, // R10
    '{32'hC0490FDB, 32'h00000000, 1'b0, 32'hC0490FDB, 1'b0, 1'b0, 8'd10}, // R10
    '{32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 1'b0, 1'b0, 8'd10}, // R10
    '{32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, 8'd10}  // R10
  };

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun;
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic offer(input logic [31:0] a, input logic [31:0] b, input logic s);
    @(negedge clk);
    inA = a; inB = b; inSub = s; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic collect(output logic [33:0] got);
    while (!outValid) @(negedge clk);
    got = {res, ovf, unf};
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog: actual=hung expected=completion");
    finishRun();
  end

  initial begin
    logic [33:0] got;
    logic [33:0] held;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 in_ready", {33'b0, inReady}, 34'd1);
    check("R12 out_valid", {33'b0, outValid}, 34'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 idle after release", {32'b0, inReady, outValid}, 34'b10);

    for (int i = 0; i < NV; i++) begin
      offer(VECS[i].a, VECS[i].b, VECS[i].sub);
      collect(got);
      checks++;
      if (got !== {VECS[i].r, VECS[i].o, VECS[i].u}) begin
        fails++;
        $display("FAIL R%0d vector %0d: actual=%h expected=%h", VECS[i].req, i,
                 got, {VECS[i].r, VECS[i].o, VECS[i].u});
      end
    end

    // R11: busy unit ignores a new offer and holds its result until taken
    offer(32'h3F800000, 32'h40000000, 1'b0);  // 1 + 2 = 3
    check("R11 not ready while busy", {33'b0, inReady}, 34'd0);
    inA = 32'h7F7FFFFF; inB = 32'h7F7FFFFF; inSub = 1'b0; inValid = 1'b1;
    @(negedge clk);
    check("R11 still busy", {33'b0, inReady}, 34'd0);
    inValid = 1'b0;
    while (!outValid) @(negedge clk);
    held = {res, ovf, unf};
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R11 valid held", {33'b0, outValid}, 34'd1);
      check("R11 result held", {res, ovf, unf}, held);
      check("R11 ready low while pending", {33'b0, inReady}, 34'd0);
    end
    check("R11 busy offer ignored", held, {32'h40400000, 2'b00});
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check("R11 released to idle", {32'b0, inReady, outValid}, 34'b10);

    // R2 R3: subtract of a negative operand becomes addition
    offer(32'h40000000, 32'hC0000000, 1'b1);  // 2 - (-2) = 4
    collect(got);
    check("R2 minus negative", got, {32'h40800000, 2'b00});

    // R4: x - x with negative x still gives +0
    offer(32'hC1200000, 32'hC1200000, 1'b1);
    collect(got);
    check("R4 negative self-cancel", got, {32'h00000000, 2'b00});

    finishRun();
  end
endmodule